// File: doc/BRIEF.md
# One-Bit SIMD Processing Array

A rectangular array of identical one-bit processing elements. Every element runs the same broadcast instruction in the same clock cycle, each on its own local state. An element holds thirteen general one-bit registers, R0 to R12, and one flag bit. Logic works like a precharged wired line. The instruction picks any subset of an element's bits to drive a shared read line, which gives their OR. The value is then stored as is or inverted, which gives NOR, into any subset of destinations. In place of its own value, an element can load the value that an orthogonal neighbour has formed in the same cycle. Elements on the array border see a global boundary bit in place of a missing neighbour, so a constant can be shifted in from any edge.

R12 takes a load only where R11 holds zero. This lets a marker in R12 grow, one step per instruction, through the region that R11 leaves open. External data reaches the array in two ways. One is a global data bit that loads into selected registers of the elements whose write-enable is set. The other is a per-element test bit that stands in for an analogue comparator and writes the flag. Any single plane can be read out, one bit per element.

The instruction port accepts one instruction per clock. `instr_ready` is tied high, so the array never applies back-pressure. An instruction is consumed on any rising edge where `instr_valid` is high, and its effect shows at the outputs after that edge.

Top module: `simd_bit_array`

## Requirements
- R1: After reset, every element holds R0..R12 = 0 and flag = 1, and `instr_ready` is 1.
- R2: The instruction is 35 bits: op [34:32], neighbour enable [31], neighbour direction [30:29], invert [28], read mask [27:14], write mask [13:0]. In both masks, bit k selects Rk and bit 13 selects the flag. Op 0 (idle) and the unused ops 5, 6 and 7 leave all state unchanged. So does any cycle with `instr_valid` low.
- R3: Op 1 (logic) forms the OR of the selected read sources, which is 0 for an empty mask. With invert set, that value is complemented before it is stored.
- R4: In op 1, every destination in the write mask captures the value, and every other bit keeps its value. All sources are read as they stood before the edge.
- R5: R12 loads, in any op, only in elements where R11 was 0 before the edge. Elsewhere R12 holds.
- R6: In op 1 with neighbour enable set, an element stores the value formed by its neighbour in the same cycle, already inverted if invert is set. Direction 0 is north (row-1), 1 is east (col+1), 2 is south (row+1), 3 is west (col-1). Element (row,col) has index row*COLS+col.
- R7: When the selected neighbour lies outside the array, the element stores `bnd_in`.
- R8: Op 2 sets the flag to 1 in every element and leaves R0..R12 unchanged.
- R9: Op 3 loads `din` into the write-mask destinations of the elements whose `ext_we` bit is 1. Elements with `ext_we` 0 keep all their state.
- R10: Op 4 loads each element's flag from its own `cmp_in` bit and leaves R0..R12 unchanged.
- R11: `plane_out[e]` shows bit `plane_sel` of element e, where 0..12 select Rk and 13 selects the flag. Codes 14 and 15 read all zeros. The output is combinational from the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_ready | output | 1 | Always 1: one instruction accepted per cycle |
| instr | input | 35 | Broadcast instruction word |
| din | input | 1 | Global data bit for op 3 |
| bnd_in | input | 1 | Value seen at the array border |
| ext_we | input | ROWS*COLS | Per-element enable for op 3 |
| cmp_in | input | ROWS*COLS | Per-element flag source for op 4 |
| plane_sel | input | 4 | Plane chosen for readout |
| plane_out | output | ROWS*COLS | Chosen plane, one bit per element |

## Verification
Every state bit can be seen through the readout, so a wrong bit in any element shows on `plane_out` one combinational read after the edge that wrote it. Stepping `plane_sel` through all sixteen codes after each instruction exposes every bit of every element. An error in the neighbour wiring or border handling shows as a plane that is shifted the wrong way, or that has a wrong edge row or column, directly after one neighbour instruction. A fault in the R12 gate shows as R12 bits changing where R11 is 1.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;
  localparam int NGEN    = 13;
  localparam int NBIT    = NGEN + 1;
  localparam int FLAG_IX = NGEN;
  localparam int GATE_IX = 11;
  localparam int COND_IX = 12;
  localparam int INSTR_W = 3 + 1 + 2 + 1 + 2 * NBIT;

  localparam logic [2:0] OPC_IDLE  = 3'd0;
  localparam logic [2:0] OPC_LOGIC = 3'd1;
  localparam logic [2:0] OPC_ALL   = 3'd2;
  localparam logic [2:0] OPC_EXT   = 3'd3;
  localparam logic [2:0] OPC_CMP   = 3'd4;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_LOGIC,
    MODE_ALL,
    MODE_EXT,
    MODE_CMP
  } mode_e;

  typedef struct packed {
    logic [2:0]      op;
    logic            nb_en;
    logic [1:0]      nb_dir;
    logic            inv;
    logic [NBIT-1:0] rd_mask;
    logic [NBIT-1:0] wr_mask;
  } instr_t;

  function automatic mode_e decode_mode(input logic vld, input logic [2:0] op);
    mode_e m;
    m = MODE_IDLE;
    if (vld) begin
      case (op)
        OPC_LOGIC: m = MODE_LOGIC;
        OPC_ALL:   m = MODE_ALL;
        OPC_EXT:   m = MODE_EXT;
        OPC_CMP:   m = MODE_CMP;
        default:   m = MODE_IDLE;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/simd_instr_dec.sv
`timescale 1ns/1ps
module simd_instr_dec
  import simd_pkg::*;
(
  input  logic                 vld,
  input  logic [INSTR_W-1:0]   word,
  output mode_e                mode,
  output logic [NBIT-1:0]      rd_mask,
  output logic [NBIT-1:0]      wr_mask,
  output logic                 inv,
  output logic                 nb_en,
  output logic [1:0]           nb_dir
);
  instr_t iw;

  always_comb begin
    iw      = instr_t'(word);
    mode    = decode_mode(vld, iw.op);
    rd_mask = iw.rd_mask;
    wr_mask = iw.wr_mask;
    inv     = iw.inv;
    nb_en   = iw.nb_en;
    nb_dir  = iw.nb_dir;
  end
endmodule

// File: rtl/simd_pe.sv
`timescale 1ns/1ps
module simd_pe
  import simd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic [NBIT-1:0]  rd_mask,
  input  logic [NBIT-1:0]  wr_mask,
  input  logic             inv,
  input  logic             nb_en,
  input  logic [1:0]       nb_dir,
  input  logic [3:0]       nb_in,
  input  logic             din,
  input  logic             ext_we,
  input  logic             cmp_in,
  output logic             bus_out,
  output logic [NBIT-1:0]  st
);
  logic            line;
  logic            own;
  logic            wval;
  logic [NBIT-1:0] ld;
  logic [NBIT-1:0] ld_gated;
  logic            val;

  always_comb begin
    line    = |(st & rd_mask);
    own     = inv ? ~line : line;
    bus_out = own;
    wval    = nb_en ? nb_in[nb_dir] : own;
  end

  always_comb begin
    ld  = '0;
    val = 1'b0;
    case (mode)
      MODE_LOGIC: begin
        ld  = wr_mask;
        val = wval;
      end
      MODE_EXT: begin
        ld  = ext_we ? wr_mask : '0;
        val = din;
      end
      MODE_ALL: begin
        ld[FLAG_IX] = 1'b1;
        val         = 1'b1;
      end
      MODE_CMP: begin
        ld[FLAG_IX] = 1'b1;
        val         = cmp_in;
      end
      default: begin
        ld  = '0;
        val = 1'b0;
      end
    endcase
    ld_gated          = ld;
    ld_gated[COND_IX] = ld[COND_IX] & ~st[GATE_IX];
  end

  for (genvar b = 0; b < NBIT; b++) begin : g_bit
    localparam logic RST_V = (b == FLAG_IX) ? 1'b1 : 1'b0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          st[b] <= RST_V;
      else if (ld_gated[b]) st[b] <= val;
    end
  end
endmodule

// File: rtl/simd_plane_mux.sv
`timescale 1ns/1ps
module simd_plane_mux
  import simd_pkg::*;
#(
  parameter int NPE = 64
) (
  input  logic [NPE*NBIT-1:0] st_flat,
  input  logic [3:0]          sel,
  output logic [NPE-1:0]      plane
);
  for (genvar e = 0; e < NPE; e++) begin : g_pe
    always_comb begin
      if (int'(sel) < NBIT) plane[e] = st_flat[e*NBIT + int'(sel)];
      else                  plane[e] = 1'b0;
    end
  end
endmodule

// File: rtl/simd_bit_array.sv
`timescale 1ns/1ps
module simd_bit_array
  import simd_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   instr_valid,
  output logic                   instr_ready,
  input  logic [INSTR_W-1:0]     instr,
  input  logic                   din,
  input  logic                   bnd_in,
  input  logic [ROWS*COLS-1:0]   ext_we,
  input  logic [ROWS*COLS-1:0]   cmp_in,
  input  logic [3:0]             plane_sel,
  output logic [ROWS*COLS-1:0]   plane_out
);
  localparam int NPE = ROWS * COLS;

  mode_e           mode;
  logic [NBIT-1:0] rd_mask;
  logic [NBIT-1:0] wr_mask;
  logic            inv;
  logic            nb_en;
  logic [1:0]      nb_dir;
  logic [NPE-1:0]  bus;
  logic [3:0]      nbv [NPE];
  logic [NPE*NBIT-1:0] st_flat;

  assign instr_ready = 1'b1;

  simd_instr_dec u_dec (
    .vld     (instr_valid),
    .word    (instr),
    .mode    (mode),
    .rd_mask (rd_mask),
    .wr_mask (wr_mask),
    .inv     (inv),
    .nb_en   (nb_en),
    .nb_dir  (nb_dir)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int E = r * COLS + c;
      if (r == 0) begin : g_n_edge
        assign nbv[E][0] = bnd_in;
      end else begin : g_n_in
        assign nbv[E][0] = bus[E - COLS];
      end
      if (c == COLS - 1) begin : g_e_edge
        assign nbv[E][1] = bnd_in;
      end else begin : g_e_in
        assign nbv[E][1] = bus[E + 1];
      end
      if (r == ROWS - 1) begin : g_s_edge
        assign nbv[E][2] = bnd_in;
      end else begin : g_s_in
        assign nbv[E][2] = bus[E + COLS];
      end
      if (c == 0) begin : g_w_edge
        assign nbv[E][3] = bnd_in;
      end else begin : g_w_in
        assign nbv[E][3] = bus[E - 1];
      end

      simd_pe u_pe (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .rd_mask (rd_mask),
        .wr_mask (wr_mask),
        .inv     (inv),
        .nb_en   (nb_en),
        .nb_dir  (nb_dir),
        .nb_in   (nbv[E]),
        .din     (din),
        .ext_we  (ext_we[E]),
        .cmp_in  (cmp_in[E]),
        .bus_out (bus[E]),
        .st      (st_flat[E*NBIT +: NBIT])
      );
    end
  end

  simd_plane_mux #(.NPE(NPE)) u_rd (
    .st_flat (st_flat),
    .sel     (plane_sel),
    .plane   (plane_out)
  );
endmodule

// File: rtl/simd_bit_array_chk.sv
`timescale 1ns/1ps
module simd_bit_array_chk
  import simd_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     instr_valid,
  input logic [INSTR_W-1:0]       instr,
  input logic [ROWS*COLS-1:0]     ext_we,
  input logic [ROWS*COLS-1:0]     cmp_in,
  input logic [3:0]               plane_sel,
  input logic [ROWS*COLS-1:0]     plane_out,
  input logic [ROWS*COLS*NBIT-1:0] st_flat
);
  localparam int NPE = ROWS * COLS;
  instr_t         iw;
  logic [NPE-1:0] flags;
  logic           quiet;

  always_comb begin
    iw    = instr_t'(instr);
    quiet = !instr_valid || (iw.op == OPC_IDLE) || (iw.op > OPC_CMP);
    for (int e = 0; e < NPE; e++) flags[e] = st_flat[e*NBIT + FLAG_IX];
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(st_flat));

  assert_all_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && iw.op == OPC_ALL) |=> (flags == {NPE{1'b1}}));

  assert_cmp_to_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && iw.op == OPC_CMP) |=> (flags == $past(cmp_in)));

  assert_unused_plane_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_sel > 4'd13) |-> (plane_out == '0));

  for (genvar e = 0; e < NPE; e++) begin : g_pe
    assert_r12_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st_flat[e*NBIT + GATE_IX] |=> $stable(st_flat[e*NBIT + COND_IX]));

    assert_ext_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && iw.op == OPC_EXT && !ext_we[e]) |=> $stable(st_flat[e*NBIT +: NBIT]));
  end
endmodule

bind simd_bit_array simd_bit_array_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .ext_we      (ext_we),
  .cmp_in      (cmp_in),
  .plane_sel   (plane_sel),
  .plane_out   (plane_out),
  .st_flat     (st_flat)
);

// File: tb/test_simd_bit_array.sv
`timescale 1ns/1ps
module test_simd_bit_array;
  import simd_pkg::*;
  localparam int ROWS = 4;
  localparam int COLS = 5;
  localparam int NPE  = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic instr_ready;
  instr_t iw = '0;
  logic din = 1'b0;
  logic bnd_in = 1'b0;
  logic [NPE-1:0] ext_we = '0;
  logic [NPE-1:0] cmp_in = '0;
  logic [3:0] plane_sel = '0;
  logic [NPE-1:0] plane_out;

  int vecs = 0;
  int errs = 0;
  logic [NBIT-1:0] m [NPE];

  always #10 clk = ~clk;

  simd_bit_array #(.ROWS(ROWS), .COLS(COLS)) i_simd_bit_array (
    .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr_ready (instr_ready),
    .instr (iw), .din (din), .bnd_in (bnd_in), .ext_we (ext_we), .cmp_in (cmp_in),
    .plane_sel (plane_sel), .plane_out (plane_out)
  );

  // reference: next state of the whole array from the requirements
  task automatic model_step(input instr_t i, input logic v);
    logic [NBIT-1:0] old [NPE];
    logic own [NPE];
    for (int e = 0; e < NPE; e++) old[e] = m[e];
    for (int e = 0; e < NPE; e++) own[e] = i.inv ^ (|(old[e] & i.rd_mask));
    if (!v) return;
    for (int e = 0; e < NPE; e++) begin
      int r = e / COLS;
      int c = e % COLS;
      logic wv;
      logic [NBIT-1:0] ld;
      ld = '0;
      wv = 1'b0;
      case (i.op)
        3'd1: begin
          ld = i.wr_mask;
          if (!i.nb_en) wv = own[e];
          else case (i.nb_dir)
            2'd0: wv = (r == 0)        ? bnd_in : own[e-COLS];
            2'd1: wv = (c == COLS - 1) ? bnd_in : own[e+1];
            2'd2: wv = (r == ROWS - 1) ? bnd_in : own[e+COLS];
            default: wv = (c == 0)     ? bnd_in : own[e-1];
          endcase
        end
        3'd2: begin ld[13] = 1'b1; wv = 1'b1; end
        3'd3: begin ld = ext_we[e] ? i.wr_mask : '0; wv = din; end
        3'd4: begin ld[13] = 1'b1; wv = cmp_in[e]; end
        default: ld = '0;
      endcase
      if (old[e][11]) ld[12] = 1'b0;
      for (int b = 0; b < NBIT; b++) if (ld[b]) m[e][b] = wv;
    end
  endtask

  task automatic check_all(input string tag);
    for (int p = 0; p < 16; p++) begin
      logic [NPE-1:0] exp;
      plane_sel = 4'(p);
      #1;
      for (int e = 0; e < NPE; e++) exp[e] = (p < NBIT) ? m[e][p] : 1'b0;
      vecs++;
      if (plane_out !== exp) begin
        errs++;
        $display("FAIL %s%s plane %0d: got %b expected %b", tag, (p > 13) ? "/R11" : "",
                 p, plane_out, exp);
      end
    end
  endtask

  task automatic issue(input instr_t i, input logic v, input string tag);
    @(negedge clk);
    iw = i;
    instr_valid = v;
    @(posedge clk);
    model_step(i, v);
    @(negedge clk);
    instr_valid = 1'b0;
    check_all(tag);
  endtask

  function automatic instr_t mk(input logic [2:0] op, input logic [13:0] rd,
                                input logic [13:0] wr, input logic inv,
                                input logic nbe, input logic [1:0] dir);
    instr_t t;
    t.op = op; t.rd_mask = rd; t.wr_mask = wr; t.inv = inv;
    t.nb_en = nbe; t.nb_dir = dir;
    return t;
  endfunction

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int e = 0; e < NPE; e++) m[e] = 14'h2000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vecs++;
    if (instr_ready !== 1'b1) begin
      errs++;
      $display("FAIL R1 ready: got %b expected 1", instr_ready);
    end
    check_all("R1");

    // R9: external loads with masked elements
    din = 1'b1; ext_we = 20'hA5C3A;
    issue(mk(3'd3, 14'h0, 14'h0001, 1'b0, 1'b0, 2'd0), 1'b1, "R9");
    din = 1'b1; ext_we = 20'h3C96F;
    issue(mk(3'd3, 14'h0, 14'h0002, 1'b0, 1'b0, 2'd0), 1'b1, "R9");
    din = 1'b0; ext_we = 20'h0F0F0;
    issue(mk(3'd3, 14'h0, 14'h0003, 1'b0, 1'b0, 2'd0), 1'b1, "R9");
    ext_we = '0;

    // R3: OR, NOR, empty mask
    issue(mk(3'd1, 14'h0003, 14'h0008, 1'b0, 1'b0, 2'd0), 1'b1, "R3");
    issue(mk(3'd1, 14'h0003, 14'h0010, 1'b1, 1'b0, 2'd0), 1'b1, "R3");
    issue(mk(3'd1, 14'h0000, 14'h0020, 1'b1, 1'b0, 2'd0), 1'b1, "R3");
    issue(mk(3'd1, 14'h0000, 14'h0020, 1'b0, 1'b0, 2'd0), 1'b1, "R3");
    // R4: several destinations, in-place swap-style read of old values
    issue(mk(3'd1, 14'h0001, 14'h00C0, 1'b0, 1'b0, 2'd0), 1'b1, "R4");
    issue(mk(3'd1, 14'h0001, 14'h0001, 1'b1, 1'b0, 2'd0), 1'b1, "R4");

    // R5: R12 only where R11 is 0
    din = 1'b1; ext_we = 20'h5A5A5;
    issue(mk(3'd3, 14'h0, 14'h0800, 1'b0, 1'b0, 2'd0), 1'b1, "R5");
    ext_we = '1;
    issue(mk(3'd3, 14'h0, 14'h1000, 1'b0, 1'b0, 2'd0), 1'b1, "R5");
    issue(mk(3'd1, 14'h0000, 14'h1000, 1'b0, 1'b0, 2'd0), 1'b1, "R5");
    ext_we = '0;

    // R6/R7: every direction, both boundary values
    for (int d = 0; d < 4; d++) begin
      for (int bv = 0; bv < 2; bv++) begin
        bnd_in = 1'(bv);
        issue(mk(3'd1, 14'h0001, 14'h0100, 1'b0, 1'b1, 2'(d)), 1'b1, "R6/R7");
        issue(mk(3'd1, 14'h0002, 14'h0200, 1'b1, 1'b1, 2'(d)), 1'b1, "R6/R7");
      end
    end

    // R10 then flag as a read source (R3) and destination (R4)
    cmp_in = 20'h9C3B1;
    issue(mk(3'd4, 14'h0, 14'h0, 1'b0, 1'b0, 2'd0), 1'b1, "R10");
    issue(mk(3'd1, 14'h2000, 14'h0400, 1'b1, 1'b0, 2'd0), 1'b1, "R3");
    issue(mk(3'd1, 14'h0001, 14'h2000, 1'b0, 1'b0, 2'd0), 1'b1, "R4");
    // R8
    issue(mk(3'd2, 14'h3FFF, 14'h3FFF, 1'b1, 1'b0, 2'd0), 1'b1, "R8");

    // R2: idle and unused codes, and valid low
    issue(mk(3'd0, 14'h3FFF, 14'h3FFF, 1'b1, 1'b0, 2'd0), 1'b1, "R2");
    for (int op = 5; op < 8; op++)
      issue(mk(3'(op), 14'h3FFF, 14'h3FFF, 1'b1, 1'b0, 2'd0), 1'b1, "R2");
    issue(mk(3'd1, 14'h0000, 14'h3FFF, 1'b1, 1'b0, 2'd0), 1'b0, "R2");

    // random sweep
    for (int k = 0; k < 400; k++) begin
      instr_t t;
      t = instr_t'({$urandom, $urandom});
      t.op = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'd1;
      din = 1'($urandom); bnd_in = 1'($urandom);
      ext_we = NPE'($urandom); cmp_in = NPE'($urandom);
      issue(t, 1'($urandom % 8 != 0), "R4/R5/R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule